// File: doc/BRIEF.md
# Tamper-Triggered Secret Erase Controller

This block guards a small store of secrets: a bank of encryption-key words and a vector memory. Both are held in plain register arrays that the surrounding logic writes and reads through simple host ports. An active-high tamper input watches for an intrusion. The input passes through a synchronizer and a run-length filter, so brief glitches are discarded and a sustained level is acted on.

When the filtered input qualifies, the block starts an erase sequence. It first walks one address counter across both arrays and writes zero into every key word and every vector word. It then holds a supply-cut output high for a fixed number of cycles, which momentarily drops the battery-backed output rail through an external switch. Finally it raises a completion flag.

While the sequence runs, the host write ports are locked out and any new tamper activity is ignored. After completion the block returns to watching the input, so a later tamper event erases the memories again.

Top module: `tamper_zeroize`

## Requirements
- R1: After reset, `supplyCut`, `eraseBusy` and `eraseDone` are all 0.
- R2: A tamper pulse that is high for at most `REJECT_CYCLES` consecutive clock samples never starts an erase. Busy stays 0 and the stored key and vector words keep their values.
- R3: A tamper pulse that is high for at least `ACCEPT_CYCLES` consecutive clock samples always starts an erase, and `eraseBusy` rises within `SYNC_STAGES + ACCEPT_CYCLES + 2` cycles of the first high sample.
- R4: Once an erase has completed, every key word reads back as zero.
- R5: Once an erase has completed, every vector word reads back as zero.
- R6: Each erase holds `supplyCut` high for exactly `CUT_CYCLES` consecutive cycles, only while `eraseBusy` is 1, after the memory sweep.
- R7: `eraseDone` rises in the cycle in which `supplyCut` falls. It is never 1 while `eraseBusy` is 1, and it stays 1 while idle until the next erase starts or reset.
- R8: Tamper activity that qualifies while an erase is in progress is ignored, so exactly one sequence runs.
- R9: Host writes to either memory have no effect while `eraseBusy` is 1.
- R10: While idle, a host write with the enable at 1 stores the data, and the read port returns it combinationally for the addressed word.
- R11: A qualified tamper event after a completed erase clears `eraseDone`, runs the full sequence again and erases data written in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tamperIn | input | 1 | Active-high tamper request, asynchronous |
| keyWrEn | input | 1 | Key bank write enable |
| keyWrAddr | input | KEY_AW | Key bank write address |
| keyWrData | input | KEY_WIDTH | Key bank write data |
| keyRdAddr | input | KEY_AW | Key bank read address |
| keyRdData | output | KEY_WIDTH | Key bank read data |
| vecWrEn | input | 1 | Vector memory write enable |
| vecWrAddr | input | VEC_AW | Vector memory write address |
| vecWrData | input | VEC_WIDTH | Vector memory write data |
| vecRdAddr | input | VEC_AW | Vector memory read address |
| vecRdData | output | VEC_WIDTH | Vector memory read data |
| supplyCut | output | 1 | High while the backed-up output rail is to be dropped |
| eraseBusy | output | 1 | Erase sequence in progress |
| eraseDone | output | 1 | Last erase sequence completed |

## Verification
The bench uses these parameter values: a reject width of 3, an accept width of 6, 4 key words of 16 bits, 12 vector words of 8 bits and a 10-cycle supply cut. With these values a full sequence takes about two dozen cycles, so many directed scenarios fit in a short run. The two arrays have different depths, so the shared sweep must clear the shorter array without running past it while still covering the longer one. The gap between the two widths is small, so pulses just under the reject width and exactly at the accept width can both be driven. The sequence is also short enough for a second tamper pulse to qualify in the middle of an erase.

// File: rtl/zeroize_pkg.sv
package zeroize_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_CUT   = 2'd2
  } zeroState_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic sweepClear;
    logic sweepStep;
    logic cutLoad;
    logic hostWrOk;
  } zeroStrobes_t;

  // Status returned by the datapath to the control FSM.
  typedef struct packed {
    logic sweepLast;
    logic cutLast;
  } zeroStatus_t;

endpackage

// File: rtl/tamper_deglitch.sv
module tamper_deglitch #(
  parameter int SYNC_STAGES   = 2,
  parameter int REJECT_CYCLES = 4,
  parameter int ACCEPT_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic tamperIn,
  output logic qualified
);
  // Trip point sits strictly above the reject width and at or below the accept width.
  localparam int TRIP = (REJECT_CYCLES + ACCEPT_CYCLES + 1) / 2;
  localparam int RUN_W = $clog2(TRIP + 1);
  localparam logic [RUN_W-1:0] TRIP_V = RUN_W'(TRIP);
  localparam logic [RUN_W-1:0] TRIP_M1 = RUN_W'(TRIP - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic syncHi;
  logic [RUN_W-1:0] runCnt;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= tamperIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[s] <= 1'b0;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  assign syncHi = syncChain[SYNC_STAGES-1];

  // Length of the current high run, saturating at the trip point.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt    <= '0;
      qualified <= 1'b0;
    end else begin
      qualified <= syncHi && (runCnt == TRIP_M1);
      if (!syncHi)              runCnt <= '0;
      else if (runCnt != TRIP_V) runCnt <= runCnt + 1'b1;
    end
  end
endmodule

// File: rtl/zeroize_ctrl.sv
module zeroize_ctrl
  import zeroize_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         qualified,
  input  zeroStatus_t  status,
  output zeroStrobes_t strobes,
  output logic         busy,
  output logic         done
);
  zeroState_t state, nextState;
  logic doneSet, doneClr;

  always_comb begin
    nextState = state;
    strobes   = '0;
    doneSet   = 1'b0;
    doneClr   = 1'b0;
    case (state)
      ST_IDLE: begin
        strobes.hostWrOk = 1'b1;
        if (qualified) begin
          nextState          = ST_SWEEP;
          strobes.sweepClear = 1'b1;
          doneClr            = 1'b1;
        end
      end
      ST_SWEEP: begin
        strobes.sweepStep = 1'b1;
        if (status.sweepLast) begin
          nextState       = ST_CUT;
          strobes.cutLoad = 1'b1;
        end
      end
      ST_CUT: begin
        if (status.cutLast) begin
          nextState = ST_IDLE;
          doneSet   = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      if (doneClr)      done <= 1'b0;
      else if (doneSet) done <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/zeroize_datapath.sv
module zeroize_datapath
  import zeroize_pkg::*;
#(
  parameter int KEY_WORDS  = 8,
  parameter int KEY_WIDTH  = 32,
  parameter int VEC_WORDS  = 64,
  parameter int VEC_WIDTH  = 16,
  parameter int CUT_CYCLES = 1000,
  localparam int KEY_AW = $clog2(KEY_WORDS),
  localparam int VEC_AW = $clog2(VEC_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  zeroStrobes_t         strobes,
  input  logic                 keyWrEn,
  input  logic [KEY_AW-1:0]    keyWrAddr,
  input  logic [KEY_WIDTH-1:0] keyWrData,
  input  logic [KEY_AW-1:0]    keyRdAddr,
  output logic [KEY_WIDTH-1:0] keyRdData,
  input  logic                 vecWrEn,
  input  logic [VEC_AW-1:0]    vecWrAddr,
  input  logic [VEC_WIDTH-1:0] vecWrData,
  input  logic [VEC_AW-1:0]    vecRdAddr,
  output logic [VEC_WIDTH-1:0] vecRdData,
  output zeroStatus_t          status,
  output logic                 supplyCut
);
  localparam int SWEEP = (KEY_WORDS > VEC_WORDS) ? KEY_WORDS : VEC_WORDS;
  localparam int SW_W  = $clog2(SWEEP + 1);
  localparam int CUT_W = $clog2(CUT_CYCLES + 1);
  localparam logic [SW_W-1:0]  KEY_LIM    = SW_W'(KEY_WORDS);
  localparam logic [SW_W-1:0]  VEC_LIM    = SW_W'(VEC_WORDS);
  localparam logic [SW_W-1:0]  SWEEP_LAST = SW_W'(SWEEP - 1);
  localparam logic [CUT_W-1:0] CUT_INIT   = CUT_W'(CUT_CYCLES);
  localparam logic [CUT_W-1:0] CUT_ONE    = CUT_W'(1);

  logic [SW_W-1:0]  sweepAddr;
  logic [CUT_W-1:0] cutCnt;
  logic [KEY_WIDTH-1:0] keyBank [KEY_WORDS];
  logic [VEC_WIDTH-1:0] vecBank [VEC_WORDS];
  logic keyWipe, vecWipe;

  assign keyWipe = strobes.sweepStep && (sweepAddr < KEY_LIM);
  assign vecWipe = strobes.sweepStep && (sweepAddr < VEC_LIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sweepAddr <= '0;
    end else if (strobes.sweepClear) begin
      sweepAddr <= '0;
    end else if (strobes.sweepStep) begin
      sweepAddr <= sweepAddr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cutCnt <= '0;
    end else if (strobes.cutLoad) begin
      cutCnt <= CUT_INIT;
    end else if (cutCnt != '0) begin
      cutCnt <= cutCnt - 1'b1;
    end
  end

  // Secret storage has no reset: the sweep is the only way it is cleared.
  always_ff @(posedge clk) begin
    if (keyWipe)                          keyBank[sweepAddr[KEY_AW-1:0]] <= '0;
    else if (strobes.hostWrOk && keyWrEn) keyBank[keyWrAddr] <= keyWrData;
  end

  always_ff @(posedge clk) begin
    if (vecWipe)                          vecBank[sweepAddr[VEC_AW-1:0]] <= '0;
    else if (strobes.hostWrOk && vecWrEn) vecBank[vecWrAddr] <= vecWrData;
  end

  assign keyRdData        = keyBank[keyRdAddr];
  assign vecRdData        = vecBank[vecRdAddr];
  assign supplyCut        = (cutCnt != '0);
  assign status.sweepLast = (sweepAddr == SWEEP_LAST);
  assign status.cutLast   = (cutCnt == CUT_ONE);
endmodule

// File: rtl/tamper_zeroize.sv
module tamper_zeroize
  import zeroize_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int REJECT_CYCLES = 4,
  parameter int ACCEPT_CYCLES = 16,
  parameter int KEY_WORDS     = 8,
  parameter int KEY_WIDTH     = 32,
  parameter int VEC_WORDS     = 64,
  parameter int VEC_WIDTH     = 16,
  parameter int CUT_CYCLES    = 1000,
  localparam int KEY_AW = $clog2(KEY_WORDS),
  localparam int VEC_AW = $clog2(VEC_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tamperIn,
  input  logic                 keyWrEn,
  input  logic [KEY_AW-1:0]    keyWrAddr,
  input  logic [KEY_WIDTH-1:0] keyWrData,
  input  logic [KEY_AW-1:0]    keyRdAddr,
  output logic [KEY_WIDTH-1:0] keyRdData,
  input  logic                 vecWrEn,
  input  logic [VEC_AW-1:0]    vecWrAddr,
  input  logic [VEC_WIDTH-1:0] vecWrData,
  input  logic [VEC_AW-1:0]    vecRdAddr,
  output logic [VEC_WIDTH-1:0] vecRdData,
  output logic                 supplyCut,
  output logic                 eraseBusy,
  output logic                 eraseDone
);
  logic         qualified;
  zeroStrobes_t strobes;
  zeroStatus_t  status;

  tamper_deglitch #(
    .SYNC_STAGES  (SYNC_STAGES),
    .REJECT_CYCLES(REJECT_CYCLES),
    .ACCEPT_CYCLES(ACCEPT_CYCLES)
  ) i_filter (
    .clk      (clk),
    .rstN     (rstN),
    .tamperIn (tamperIn),
    .qualified(qualified)
  );

  zeroize_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .qualified(qualified),
    .status   (status),
    .strobes  (strobes),
    .busy     (eraseBusy),
    .done     (eraseDone)
  );

  zeroize_datapath #(
    .KEY_WORDS (KEY_WORDS),
    .KEY_WIDTH (KEY_WIDTH),
    .VEC_WORDS (VEC_WORDS),
    .VEC_WIDTH (VEC_WIDTH),
    .CUT_CYCLES(CUT_CYCLES)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .keyWrEn  (keyWrEn),
    .keyWrAddr(keyWrAddr),
    .keyWrData(keyWrData),
    .keyRdAddr(keyRdAddr),
    .keyRdData(keyRdData),
    .vecWrEn  (vecWrEn),
    .vecWrAddr(vecWrAddr),
    .vecWrData(vecWrData),
    .vecRdAddr(vecRdAddr),
    .vecRdData(vecRdData),
    .status   (status),
    .supplyCut(supplyCut)
  );
endmodule

// File: rtl/tamper_zeroize_chk.sv
module tamper_zeroize_chk #(
  parameter int CUT_CYCLES = 1000,
  parameter int KEY_AW     = 3,
  parameter int KEY_WIDTH  = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 supplyCut,
  input logic                 eraseBusy,
  input logic                 eraseDone,
  input logic [KEY_AW-1:0]    keyRdAddr,
  input logic [KEY_WIDTH-1:0] keyRdData
);
  int cutRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cutRun <= 0;
    else if (supplyCut) cutRun <= cutRun + 1;
    else                cutRun <= 0;
  end

  assert_cut_in_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    supplyCut |-> eraseBusy);

  assert_cut_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    supplyCut |-> (cutRun < CUT_CYCLES));

  assert_cut_length_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(supplyCut) |-> (cutRun == CUT_CYCLES));

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    eraseDone |-> !eraseBusy);

  assert_done_at_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eraseDone) |-> $fell(supplyCut));

  assert_busy_end_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eraseBusy) |-> eraseDone);

  assert_no_host_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(eraseBusy) && $stable(keyRdAddr) && (keyRdData != $past(keyRdData)))
      |-> (keyRdData == '0));
endmodule

bind tamper_zeroize tamper_zeroize_chk #(
  .CUT_CYCLES(CUT_CYCLES),
  .KEY_AW    (KEY_AW),
  .KEY_WIDTH (KEY_WIDTH)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .supplyCut(supplyCut),
  .eraseBusy(eraseBusy),
  .eraseDone(eraseDone),
  .keyRdAddr(keyRdAddr),
  .keyRdData(keyRdData)
);

// File: tb/test_tamper_zeroize.sv
`timescale 1ns/1ps
module test_tamper_zeroize;
  localparam int SYNC = 2, REJ = 3, ACC = 6, KW = 4, KWID = 16, VW = 12, VWID = 8, CUT = 10;
  localparam int KAW = $clog2(KW), VAW = $clog2(VW);

  logic clk = 1'b0, rstN = 1'b0, tamperIn = 1'b0;
  logic keyWrEn = 1'b0, vecWrEn = 1'b0;
  logic [KAW-1:0] keyWrAddr = '0, keyRdAddr = '0;
  logic [KWID-1:0] keyWrData = '0, keyRdData;
  logic [VAW-1:0] vecWrAddr = '0, vecRdAddr = '0;
  logic [VWID-1:0] vecWrData = '0, vecRdData;
  logic supplyCut, eraseBusy, eraseDone;

  int checks = 0, failures = 0, cutSeen = 0, runs = 0;
  bit prevBusy = 1'b0, finished = 1'b0;

  always #5 clk = ~clk;

  tamper_zeroize #(
    .SYNC_STAGES(SYNC), .REJECT_CYCLES(REJ), .ACCEPT_CYCLES(ACC),
    .KEY_WORDS(KW), .KEY_WIDTH(KWID), .VEC_WORDS(VW), .VEC_WIDTH(VWID), .CUT_CYCLES(CUT)
  ) i_tamper_zeroize (
    .clk(clk), .rstN(rstN), .tamperIn(tamperIn),
    .keyWrEn(keyWrEn), .keyWrAddr(keyWrAddr), .keyWrData(keyWrData),
    .keyRdAddr(keyRdAddr), .keyRdData(keyRdData),
    .vecWrEn(vecWrEn), .vecWrAddr(vecWrAddr), .vecWrData(vecWrData),
    .vecRdAddr(vecRdAddr), .vecRdData(vecRdData),
    .supplyCut(supplyCut), .eraseBusy(eraseBusy), .eraseDone(eraseDone)
  );

  // Observers sample between edges.
  always @(negedge clk) begin
    if (rstN) begin
      if (supplyCut) cutSeen++;
      if (eraseBusy && !prevBusy) runs++;
      prevBusy = eraseBusy;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    tamperIn = 1'b1;
    cycles(n);
    tamperIn = 1'b0;
  endtask

  task automatic writeKey(input int a, input logic [KWID-1:0] d);
    keyWrAddr = KAW'(a); keyWrData = d; keyWrEn = 1'b1;
    cycles(1);
    keyWrEn = 1'b0;
  endtask

  task automatic writeVec(input int a, input logic [VWID-1:0] d);
    vecWrAddr = VAW'(a); vecWrData = d; vecWrEn = 1'b1;
    cycles(1);
    vecWrEn = 1'b0;
  endtask

  task automatic fillAll();
    for (int i = 0; i < KW; i++) writeKey(i, KWID'(16'hA500 + i));
    for (int i = 0; i < VW; i++) writeVec(i, VWID'(8'h30 + i));
  endtask

  task automatic waitBusy(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < SYNC + ACC + 2; i++) begin
      if (eraseBusy) begin seen = 1'b1; break; end
      cycles(1);
    end
    if (eraseBusy) seen = 1'b1;
  endtask

  task automatic waitDone(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (eraseDone) begin seen = 1'b1; break; end
      cycles(1);
    end
  endtask

  task automatic checkAllZero(input string tag);
    bit keyOk = 1'b1, vecOk = 1'b1;
    longint bad = 0;
    for (int i = 0; i < KW; i++) begin
      keyRdAddr = KAW'(i); #1;
      if (keyRdData != '0) begin keyOk = 1'b0; bad = keyRdData; end
    end
    check(keyOk, "R4", {tag, " key words zero"}, bad, 0);
    bad = 0;
    for (int i = 0; i < VW; i++) begin
      vecRdAddr = VAW'(i); #1;
      if (vecRdData != '0) begin vecOk = 1'b0; bad = vecRdData; end
    end
    check(vecOk, "R5", {tag, " vector words zero"}, bad, 0);
  endtask

  task automatic testReset();
    check(!supplyCut && !eraseBusy && !eraseDone, "R1", "outputs after reset",
          {supplyCut, eraseBusy, eraseDone}, 0);
  endtask

  task automatic testHostAccess();
    fillAll();
    keyRdAddr = KAW'(2); vecRdAddr = VAW'(11); #1;
    check(keyRdData == 16'hA502, "R10", "key readback", keyRdData, 16'hA502);
    check(vecRdData == 8'h3B, "R10", "vector readback", vecRdData, 8'h3B);
  endtask

  task automatic testShortPulses();
    int r0 = runs;
    pulse(REJ); cycles(6);
    pulse(1);   cycles(6);
    pulse(REJ); cycles(20);
    check(runs == r0 && !eraseBusy, "R2", "short pulses start nothing", runs - r0, 0);
    keyRdAddr = KAW'(1); vecRdAddr = VAW'(5); #1;
    check(keyRdData == 16'hA501, "R2", "key kept after short pulses", keyRdData, 16'hA501);
    check(vecRdData == 8'h35, "R2", "vector kept after short pulses", vecRdData, 8'h35);
  endtask

  task automatic testErase();
    bit seen;
    int r0 = runs;
    cutSeen = 0;
    pulse(ACC);
    waitBusy(seen);
    check(seen, "R3", "accept-width pulse starts erase", eraseBusy, 1);
    cycles(3);
    writeKey(0, 16'hBEEF);           // during sweep, after word 0 is wiped
    while (!supplyCut && eraseBusy) cycles(1);
    writeVec(0, 8'h77);              // during the supply cut
    check(!eraseDone, "R7", "done low while busy", eraseDone, 0);
    waitDone(seen);
    check(seen && !eraseBusy, "R7", "done after sequence", eraseDone, 1);
    check(cutSeen == CUT, "R6", "supply cut length", cutSeen, CUT);
    check(runs == r0 + 1, "R3", "one sequence run", runs - r0, 1);
    checkAllZero("after erase");
    keyRdAddr = '0; vecRdAddr = '0; #1;
    check(keyRdData == '0 && vecRdData == '0, "R9", "writes while busy ignored",
          {keyRdData, vecRdData}, 0);
    cycles(20);
    check(eraseDone && !eraseBusy && !supplyCut, "R7", "done held while idle", eraseDone, 1);
  endtask

  task automatic testPulseDuringErase();
    bit seen;
    int r0 = runs;
    fillAll();
    pulse(ACC);
    waitBusy(seen);
    cycles(1);
    pulse(ACC + 2);                  // qualifies well inside the sequence
    waitDone(seen);
    cycles(30);
    check(runs == r0 + 1, "R8", "tamper during erase ignored", runs - r0, 1);
    check(eraseDone && !eraseBusy, "R8", "idle and done after ignored pulse", eraseBusy, 0);
  endtask

  task automatic testRetrigger();
    bit seen;
    writeKey(3, 16'h1234);
    keyRdAddr = KAW'(3); #1;
    check(keyRdData == 16'h1234, "R10", "write after done", keyRdData, 16'h1234);
    cutSeen = 0;
    pulse(ACC + 4);
    waitBusy(seen);
    check(seen && !eraseDone, "R11", "retrigger clears done", eraseDone, 0);
    waitDone(seen);
    check(seen && cutSeen == CUT, "R11", "second full sequence", cutSeen, CUT);
    checkAllZero("after retrigger");
  endtask

  initial begin
    cycles(3);
    testReset();
    rstN = 1'b1;
    cycles(2);
    testReset();
    testHostAccess();
    testShortPulses();
    testErase();
    testPulseDuringErase();
    testRetrigger();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule